// File: doc/BRIEF.md
# Frame-Sync Serial Converter Front End

This block is the digital serial front end of an eight-input sampling converter that exchanges data with a DSP through frame-sync framing. Every register runs on the edges of the external bit clock `sclk`. Command bits are taken from `din` on falling edges. Result bits and the outgoing frame pulse change on rising edges. A frame opens when the DSP's frame-sync input `dspr` is seen high on a falling edge while `cs_n` is low. That edge is edge zero, and the cycles after it are numbered 1, 2, and so on. Cycle k has a rising edge Rk followed by a falling edge Fk.

The block takes in a 16-bit command word and latches a 3-bit channel number from the start of that word. It then drives an acquire window and a sample strobe at fixed cycle counts. One cycle before the result starts, it issues its own frame-sync pulse on `dspx`. It then shifts out the 14-bit parallel result `conv_data`, left-aligned in a 16-bit field. A full transfer takes 32 cycles.

A new `dspr` pulse restarts the sequence from any point. Raising `cs_n` while a frame is active puts the block into shutdown.

The controller has five states:
- IDLE: the reset state.
- CMD: command and acquisition, cycles 1 to 16.
- XFER: result shift, cycles 17 to 32.
- TRAIL: zeros after the field.
- SHDN: shutdown.

The transitions are:
- **start/restart**: any state goes to CMD when `dspr` is high and `cs_n` is low.
- **cmd_done**: CMD goes to XFER at F16.
- **xfer_done**: XFER goes to TRAIL at F32.
- **power_down**: CMD, XFER or TRAIL go to SHDN when `cs_n` is high.
- **reset**: any state goes to IDLE.

Top module: `dspfs_top`

## Requirements
- R1: Command bits are taken from `din` at F1 through F16, first bit as the most significant. After F16, `cmd_word` holds the whole word.
- R2: At F3, `channel` takes command bits 15..13 (the first three bits shifted in). It holds that value until the next frame latches a new one.
- R3: `acquire` is high from F3 until R15 and low at every other time. It is never high together with `sample`.
- R4: `sample` is a single-cycle pulse that is high from R15 to R16.
- R5: `dspx` is a single-cycle pulse that is high from R16 to R17.
- R6: `conv_data` is captured at R16. At R17 through R32, `dout` carries {conv_data, 2'b00}, most significant bit first.
- R7: From R33 until the next frame starts, `dout` is 0.
- R8: When `dspr` is high and `cs_n` is low at any falling edge, that edge becomes edge zero of a new frame. Any frame in progress is abandoned, and its outputs do not continue.
- R9: When `cs_n` is high at a falling edge while a frame is active, the block enters shutdown. In shutdown, `dout`, `dspx`, `sample` and `acquire` stay 0. `cs_n` high takes priority over a `dspr` pulse at the same edge.
- R10: The only way out of shutdown is a `dspr` pulse with `cs_n` low. A `dspr` pulse with `cs_n` high, or `cs_n` low without a pulse, leaves the block quiet.
- R11: While `rst_n` is low, the block returns to IDLE at once. All outputs, `channel` and `cmd_word` are 0, including when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous reset, active low |
| sclk | input | 1 | External serial bit clock |
| cs_n | input | 1 | Chip select, active low |
| dspr | input | 1 | Incoming frame-sync pulse from the DSP |
| din | input | 1 | Serial command input |
| conv_data | input | 14 | Parallel conversion result |
| dspx | output | 1 | Outgoing frame-sync pulse |
| dout | output | 1 | Serial result output |
| channel | output | 3 | Decoded input channel |
| acquire | output | 1 | Acquisition window |
| sample | output | 1 | Sample-instant strobe |
| cmd_word | output | 16 | Last captured command word |

## Verification
Two functions can fall on the same falling edge of `sclk`: the restart caused by a `dspr` pulse, and the shutdown caused by `cs_n` being high. Random frames are cut short at random cycles, some during command capture and some during the result shift. The frame that follows is then checked from its first cycle, which shows that the abandoned frame left no bits on `dout`. A directed case raises `cs_n` and `dspr` together in the middle of a transfer. Correct behaviour there is shutdown: the outputs stay quiet, no strobe appears in the cycles where the restarted frame would have produced one, and the block leaves shutdown only at a later pulse with `cs_n` low.

// File: rtl/dspfs_pkg.sv
package dspfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_XFER,
        ST_TRAIL,
        ST_SHDN
    } fs_state_t;
endpackage

// File: rtl/dspfs_frame_ctl.sv
module dspfs_frame_ctl
    import dspfs_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int CNT_W = 6
) (
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             dspr,
    output fs_state_t        st,
    output logic [CNT_W-1:0] cnt,
    output logic             restart
);
    localparam logic [CNT_W-1:0] CMD_LAST  = CNT_W'(CMD_W - 1);
    localparam logic [CNT_W-1:0] XFER_LAST = CNT_W'(2 * CMD_W - 1);

    fs_state_t        st_n;
    logic [CNT_W-1:0] cnt_n;
    logic             active;

    always_comb begin
        restart = dspr & ~cs_n;
        active  = (st == ST_CMD) || (st == ST_XFER) || (st == ST_TRAIL);
    end

    // next-state and counter
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        if (restart) begin
            st_n  = ST_CMD;
            cnt_n = '0;
        end else if (cs_n && active) begin
            st_n  = ST_SHDN;
            cnt_n = '0;
        end else begin
            unique case (st)
                ST_CMD: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == CMD_LAST) st_n = ST_XFER;
                end
                ST_XFER: begin
                    cnt_n = cnt + CNT_W'(1);
                    if (cnt == XFER_LAST) st_n = ST_TRAIL;
                end
                ST_IDLE, ST_TRAIL, ST_SHDN: begin
                    st_n  = st;
                    cnt_n = cnt;
                end
            endcase
        end
    end

    // state register
    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end
endmodule

// File: rtl/dspfs_cmd_shift.sv
module dspfs_cmd_shift
    import dspfs_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int CH_W  = 3,
    parameter int CNT_W = 6
) (
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             din,
    input  logic             restart,
    input  fs_state_t        st,
    input  logic [CNT_W-1:0] cnt,
    output logic [CMD_W-1:0] cmd_word,
    output logic [CH_W-1:0]  channel
);
    localparam logic [CNT_W-1:0] CH_LAST = CNT_W'(CH_W - 1);

    always_ff @(negedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_word <= '0;
            channel  <= '0;
        end else if (restart) begin
            cmd_word <= '0;
        end else if (st == ST_CMD) begin
            cmd_word <= {cmd_word[CMD_W-2:0], din};
            if (cnt == CH_LAST) begin
                channel <= {cmd_word[CH_W-2:0], din};
            end
        end
    end
endmodule

// File: rtl/dspfs_result_tx.sv
module dspfs_result_tx
    import dspfs_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int RES_W = 14,
    parameter int CH_W  = 3,
    parameter int CNT_W = 6
) (
    input  logic             rst_n,
    input  logic             sclk,
    input  fs_state_t        st,
    input  logic [CNT_W-1:0] cnt,
    input  logic [RES_W-1:0] conv_data,
    output logic             acquire,
    output logic             sample,
    output logic             dspx,
    output logic             dout
);
    localparam int               PAD_W    = CMD_W - RES_W;
    localparam logic [CNT_W-1:0] ACQ_CNT  = CNT_W'(CH_W);
    localparam logic [CNT_W-1:0] SAMP_CNT = CNT_W'(CMD_W - 2);
    localparam logic [CNT_W-1:0] FS_CNT   = CNT_W'(CMD_W - 1);

    logic             sample_q;
    logic             dspx_q;
    logic             dout_q;
    logic [CMD_W-1:0] shreg;
    logic             in_cmd;

    always_comb in_cmd = (st == ST_CMD);

    always_ff @(posedge sclk or negedge rst_n) begin
        if (!rst_n) begin
            sample_q <= 1'b0;
            dspx_q   <= 1'b0;
            dout_q   <= 1'b0;
            shreg    <= '0;
        end else begin
            sample_q <= in_cmd && (cnt == SAMP_CNT);
            dspx_q   <= in_cmd && (cnt == FS_CNT);
            if (in_cmd && (cnt == FS_CNT)) begin
                shreg  <= {conv_data, {PAD_W{1'b0}}};
                dout_q <= 1'b0;
            end else if (st == ST_XFER) begin
                dout_q <= shreg[CMD_W-1];
                shreg  <= {shreg[CMD_W-2:0], 1'b0};
            end else begin
                dout_q <= 1'b0;
            end
        end
    end

    // outputs gated by the current state so aborts silence them at once
    always_comb begin
        acquire = in_cmd && (cnt >= ACQ_CNT) && (cnt <= SAMP_CNT) && !sample_q;
        sample  = sample_q && in_cmd;
        dspx    = dspx_q && (st != ST_IDLE) && (st != ST_SHDN);
        dout    = dout_q && ((st == ST_XFER) || (st == ST_TRAIL));
    end
endmodule

// File: rtl/dspfs_top.sv
module dspfs_top
    import dspfs_pkg::*;
#(
    parameter int CMD_W = 16,
    parameter int RES_W = 14,
    parameter int CH_W  = 3,
    parameter int CNT_W = 6
) (
    input  logic             rst_n,
    input  logic             sclk,
    input  logic             cs_n,
    input  logic             dspr,
    input  logic             din,
    input  logic [RES_W-1:0] conv_data,
    output logic             dspx,
    output logic             dout,
    output logic [CH_W-1:0]  channel,
    output logic             acquire,
    output logic             sample,
    output logic [CMD_W-1:0] cmd_word
);
    fs_state_t        frame_st;
    logic [CNT_W-1:0] frame_cnt;
    logic             frame_restart;

    dspfs_frame_ctl #(.CMD_W(CMD_W), .CNT_W(CNT_W)) ctl_i (
        .rst_n   (rst_n),
        .sclk    (sclk),
        .cs_n    (cs_n),
        .dspr    (dspr),
        .st      (frame_st),
        .cnt     (frame_cnt),
        .restart (frame_restart)
    );

    dspfs_cmd_shift #(.CMD_W(CMD_W), .CH_W(CH_W), .CNT_W(CNT_W)) cmd_i (
        .rst_n    (rst_n),
        .sclk     (sclk),
        .din      (din),
        .restart  (frame_restart),
        .st       (frame_st),
        .cnt      (frame_cnt),
        .cmd_word (cmd_word),
        .channel  (channel)
    );

    dspfs_result_tx #(.CMD_W(CMD_W), .RES_W(RES_W), .CH_W(CH_W), .CNT_W(CNT_W)) tx_i (
        .rst_n     (rst_n),
        .sclk      (sclk),
        .st        (frame_st),
        .cnt       (frame_cnt),
        .conv_data (conv_data),
        .acquire   (acquire),
        .sample    (sample),
        .dspx      (dspx),
        .dout      (dout)
    );
endmodule

// File: rtl/dspfs_checker.sv
module dspfs_checker
    import dspfs_pkg::*;
(
    input logic      rst_n,
    input logic      sclk,
    input logic      cs_n,
    input logic      dspr,
    input fs_state_t st,
    input logic      dout,
    input logic      dspx,
    input logic      sample,
    input logic      acquire
);
    assert_sample_single_R4: assert property (@(posedge sclk) disable iff (!rst_n)
        sample |=> !sample);

    assert_fsync_single_R5: assert property (@(posedge sclk) disable iff (!rst_n)
        dspx |=> !dspx);

    assert_strobe_excl_R3: assert property (@(posedge sclk) disable iff (!rst_n)
        !(sample && acquire));

    assert_shdn_quiet_R9: assert property (@(negedge sclk) disable iff (!rst_n)
        (st == ST_SHDN) |-> (!dout && !dspx && !sample && !acquire));

    assert_restart_R8: assert property (@(negedge sclk) disable iff (!rst_n)
        (dspr && !cs_n) |=> (st == ST_CMD));
endmodule

bind dspfs_top dspfs_checker chk_i (
    .rst_n   (rst_n),
    .sclk    (sclk),
    .cs_n    (cs_n),
    .dspr    (dspr),
    .st      (frame_st),
    .dout    (dout),
    .dspx    (dspx),
    .sample  (sample),
    .acquire (acquire)
);

// File: tb/dspfs_top_tb_top.sv
module dspfs_top_tb_top;
    localparam int TCLK = 20;

    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        cs_n = 1'b1;
    logic        dspr = 1'b0;
    logic        din = 1'b0;
    logic [13:0] conv_data = '0;
    logic        dspx, dout, acquire, sample;
    logic [2:0]  channel;
    logic [15:0] cmd_word;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    dspfs_top dut_i (
        .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dspr(dspr), .din(din),
        .conv_data(conv_data), .dspx(dspx), .dout(dout), .channel(channel),
        .acquire(acquire), .sample(sample), .cmd_word(cmd_word)
    );

    always #(TCLK/2) sclk = ~sclk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
        end
    endtask

    function automatic logic exp_dout(input logic [13:0] data, input int k);
        logic [15:0] field;
        field = {data, 2'b00};
        if (k >= 17 && k <= 32) return field[32-k];
        return 1'b0;
    endfunction

    // one frame: pulse dspr, then observe cycles 1..len
    task automatic run_frame(input logic [15:0] cmd, input logic [13:0] data,
                             input int len, input string note);
        @(posedge sclk); #1;
        dspr = 1'b1; cs_n = 1'b0; conv_data = data;
        for (int k = 1; k <= len; k++) begin
            @(posedge sclk); #1;
            dspr = 1'b0;
            din = (k <= 16) ? cmd[16-k] : 1'($urandom % 2);
            #(TCLK/4 - 1);
            chk({"R4 sample ", note}, sample, k == 15);
            chk({"R5 dspx ", note}, dspx, k == 16);
            chk({(k > 32) ? "R7 trailing zero " : "R6 dout bit ", note}, dout, exp_dout(data, k));
            chk({"R3 acquire high phase ", note}, acquire, (k >= 4 && k <= 14));
            @(negedge sclk); #(TCLK/4);
            chk({"R3 acquire low phase ", note}, acquire, (k >= 3 && k <= 14));
            if (k == 3)  chk({"R2 channel ", note}, channel, cmd[15:13]);
            if (k == 16) chk({"R1 cmd_word ", note}, cmd_word, cmd);
        end
    endtask

    task automatic quiet_cycles(input int n, input string req);
        for (int j = 0; j < n; j++) begin
            @(posedge sclk); #(TCLK/4);
            chk({req, " dout"}, dout, 0);
            chk({req, " dspx"}, dspx, 0);
            chk({req, " sample"}, sample, 0);
            @(negedge sclk); #(TCLK/4);
            chk({req, " acquire"}, acquire, 0);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(TCLK * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got hang expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        string note;
        bit prev_abort;
        void'($urandom(32'd4711));
        #(3 * TCLK + 3);
        // R11 reset state
        chk("R11 reset dout", dout, 0);
        chk("R11 reset dspx", dspx, 0);
        chk("R11 reset sample", sample, 0);
        chk("R11 reset acquire", acquire, 0);
        chk("R11 reset channel", channel, 0);
        chk("R11 reset cmd_word", cmd_word, 0);
        rst_n = 1'b1;
        quiet_cycles(3, "R11 idle");

        // directed frames with extreme patterns
        run_frame(16'hFFFF, 14'h3FFF, 36, "all ones");
        run_frame(16'h0000, 14'h0000, 34, "all zeros");
        run_frame(16'hA5C3, 14'h2AAA, 32, "alternating");

        // R8 abort during transfer, then a full frame
        run_frame(16'h6123, 14'h3FFF, 24, "before abort");
        run_frame(16'h2F0F, 14'h1234, 34, "R8 after xfer abort");

        // R9 cs_n and dspr high at the same edge mid-transfer
        run_frame(16'hC001, 14'h3ABC, 19, "before shutdown");
        @(posedge sclk); #1; cs_n = 1'b1; dspr = 1'b1;
        @(posedge sclk); #1; dspr = 1'b0;
        quiet_cycles(20, "R9 shutdown");
        // R10 dspr with cs_n high ignored, then cs_n low alone
        @(posedge sclk); #1; dspr = 1'b1;
        @(posedge sclk); #1; dspr = 1'b0;
        quiet_cycles(20, "R10 dspr with cs high");
        cs_n = 1'b0;
        quiet_cycles(5, "R10 cs low no pulse");
        run_frame(16'h4567, 14'h0F0F, 33, "R10 wake");

        // random mix with aborts
        prev_abort = 0;
        for (int f = 0; f < 30; f++) begin
            logic [15:0] c;
            logic [13:0] d;
            int len;
            c = 16'($urandom);
            d = 14'($urandom);
            if ($urandom % 3 == 0) len = 2 + int'($urandom % 30);
            else len = 32 + int'($urandom % 5);
            note = prev_abort ? "R8 random after abort" : "random";
            run_frame(c, d, len, note);
            prev_abort = (len < 32);
        end

        // R11 reset in mid-frame
        run_frame(16'hE3E3, 14'h3333, 20, "before reset");
        #2; rst_n = 1'b0; #1;
        chk("R11 mid reset dout", dout, 0);
        chk("R11 mid reset channel", channel, 0);
        chk("R11 mid reset cmd_word", cmd_word, 0);
        chk("R11 mid reset dspx", dspx, 0);
        #(TCLK); rst_n = 1'b1;
        quiet_cycles(4, "R11 after reset");

        done = 1;
        summary();
        $finish;
    end
endmodule